// File: doc/BRIEF.md
# Register Readiness Interlock with Per-Stage Read Advance

This block sits beside the issue stage of a statically scheduled, dual-issue pipeline. For every architectural register it keeps a small down-counter holding the number of cycles still to pass before the value being produced for that register can be forwarded. An issuing instruction loads its destination's counter with a latency taken from its latency class. The counter then runs down by one per cycle until it stops at zero.

Each candidate instruction that wants to issue presents up to `NSRC` source registers. With each source it gives a code for the stage in which that source is actually consumed. A source read later in the pipe can tolerate a producer that is still some cycles away. The block grants the source once the remaining count is no larger than the advance of its read stage. A candidate is ready when every valid source is granted, and the block drives the matching stall otherwise. A flush input wipes all pending countdowns at once. Resource availability and the datapath belong to the surrounding issue logic.

Top module: `sbi_interlock`

## Requirements
- R1: After synchronous reset every counter is zero, so every candidate reports ready and no stall.
- R2: The class code on an issue slot selects the loaded latency: 0 plain ALU = 3, 1 shifted-operand ALU = 4, 2 load = 4, 3 multiply-accumulate = 4, 4 single-precision divide = 7, 5 double-precision divide = 17, 6 and 7 = 0.
- R3: A counter that receives no write and no flush decreases by exactly one per cycle and holds at zero.
- R4: A new write to a register replaces its count with the new latency, shorter or longer than what remained.
- R5: When several slots write the same register in one cycle, the highest-numbered slot (the younger instruction) sets the count.
- R6: The 2-bit read-stage code gives the advance: code 0 → 0, code 1 → 1, code 2 → 2, and code 3 → 0.
- R7: A valid source is granted when its register's count is at most its advance. A candidate's ready is high when all its valid sources are granted, and its stall is the inverse of ready.
- R8: A source whose valid bit is low never causes a stall, whatever register and stage it names.
- R9: Flush zeroes every counter at the next edge and takes priority over writes issued in the same cycle.
- R10: A write becomes visible to candidates from the cycle after its issue. A candidate judged in the issue cycle itself sees the count from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Clears all countdowns |
| iss_vld_i | input | ISSUE_W | Issue slot valid, slot 0 oldest |
| iss_dst_i | input | ISSUE_W*RW | Destination register per slot |
| iss_cls_i | input | ISSUE_W*3 | Latency class code per slot |
| src_vld_i | input | NCAND*NSRC | Source valid per candidate source |
| src_reg_i | input | NCAND*NSRC*RW | Source register per candidate source |
| src_stg_i | input | NCAND*NSRC*2 | Read-stage code per candidate source |
| cand_ready_o | output | NCAND | Candidate may issue |
| cand_stall_o | output | NCAND | Candidate must wait |

## Verification
The hardest case to reach from the ports is a counter that is rewritten in the middle of a long countdown. This can shorten the count, lengthen it, or be cancelled by a flush arriving in the same cycle as a write. On top of that, two slots may target one register while a candidate reads that same register in the issue cycle. Directed sequences pin a double-precision divide result to one register. They then overlay short and long writes, same-cycle slot collisions and flushes at chosen offsets, and probe the register every cycle from all four stage codes. A long random phase follows, with registers drawn from a small subset so that such overlaps keep recurring.

// File: rtl/sbi_pkg.sv
// Package: shared encodings for the register readiness interlock.
// Assumes class codes are 3 bits and read-stage codes are 2 bits.
package sbi_pkg;

    localparam int CLS_W = 3;
    localparam int STG_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU     = 3'd0,
        CLS_ALU_SHF = 3'd1,
        CLS_LOAD    = 3'd2,
        CLS_MAC     = 3'd3,
        CLS_FDIV_S  = 3'd4,
        CLS_FDIV_D  = 3'd5,
        CLS_RSV6    = 3'd6,
        CLS_RSV7    = 3'd7
    } lat_class_e;

    // Largest of six latencies, used to size the counters.
    function automatic int max_of6(input int a, input int b, input int c,
                                   input int d, input int e, input int f);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        if (f > m) m = f;
        return m;
    endfunction

endpackage

// File: rtl/sbi_lat_decode.sv
// Module: maps a latency class code to a countdown load value.
// Assumes every latency fits in CNT_W bits; reserved codes load zero.
module sbi_lat_decode
    import sbi_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int LAT_ALU  = 3,
    parameter int LAT_SHF  = 4,
    parameter int LAT_LD   = 4,
    parameter int LAT_MAC  = 4,
    parameter int LAT_DIVS = 7,
    parameter int LAT_DIVD = 17
) (
    input  logic [CLS_W-1:0] cls_i,
    output logic [CNT_W-1:0] lat_o
);

    // Class to latency lookup.
    always_comb begin
        unique case (lat_class_e'(cls_i))
            CLS_ALU:     lat_o = CNT_W'(LAT_ALU);
            CLS_ALU_SHF: lat_o = CNT_W'(LAT_SHF);
            CLS_LOAD:    lat_o = CNT_W'(LAT_LD);
            CLS_MAC:     lat_o = CNT_W'(LAT_MAC);
            CLS_FDIV_S:  lat_o = CNT_W'(LAT_DIVS);
            CLS_FDIV_D:  lat_o = CNT_W'(LAT_DIVD);
            default:     lat_o = '0;
        endcase
    end

endmodule

// File: rtl/sbi_reg_counter.sv
// Module: one register's remaining-latency down-counter.
// Assumes flush outranks a write, and a write outranks the decrement.
module sbi_reg_counter #(
    parameter int CNT_W   = 5,
    parameter int LAT_MAX = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_lat_i,
    output logic [CNT_W-1:0] cnt_o
);

    // Load, run down to zero, or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            cnt_o <= '0;
        end else if (wr_en_i) begin
            cnt_o <= wr_lat_i;
        end else if (cnt_o != '0) begin
            cnt_o <= cnt_o - 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_W'(LAT_MAX)); // R2
    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (cnt_o == '0)); // R9
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !flush_i) |=> (cnt_o == $past(wr_lat_i))); // R4
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !flush_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1)); // R3
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && cnt_o == '0) |=> (cnt_o == '0)); // R3

endmodule

// File: rtl/sbi_src_check.sv
// Module: readiness of one candidate from its sources' read stages.
// Assumes all counts arrive flattened, register r at bits [r*CNT_W +: CNT_W].
module sbi_src_check
    import sbi_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int NSRC  = 2,
    parameter int CNT_W = 5,
    localparam int RW   = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NREG*CNT_W-1:0] cnt_flat_i,
    input  logic [NSRC-1:0]       vld_i,
    input  logic [NSRC*RW-1:0]    reg_i,
    input  logic [NSRC*STG_W-1:0] stg_i,
    output logic                  ready_o
);

    logic [NSRC-1:0] grant;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic [RW-1:0]    idx;
        logic [STG_W-1:0] stg;
        logic [CNT_W-1:0] adv;
        logic [CNT_W-1:0] cnt;

        // Read-stage code to advance, then compare with remaining count.
        always_comb begin
            idx = reg_i[s*RW +: RW];
            stg = stg_i[s*STG_W +: STG_W];
            adv = (stg == 2'd3) ? '0 : CNT_W'(stg);
            cnt = cnt_flat_i[idx*CNT_W +: CNT_W];
            grant[s] = !vld_i[s] || (cnt <= adv);
        end
    end

    assign ready_o = &grant;

    AST_IDLE_SRC_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i == '0) |-> ready_o); // R8

endmodule

// File: rtl/sbi_interlock.sv
// Module: top of the register readiness interlock.
// Keeps one countdown per register, loads it from issue slots (younger
// slot wins), and grants candidates whose sources are close enough.
// Assumes slot index order equals program order, slot 0 oldest.
module sbi_interlock
    import sbi_pkg::*;
#(
    parameter int NREG     = 16,
    parameter int ISSUE_W  = 2,
    parameter int NCAND    = 2,
    parameter int NSRC     = 2,
    parameter int LAT_ALU  = 3,
    parameter int LAT_SHF  = 4,
    parameter int LAT_LD   = 4,
    parameter int LAT_MAC  = 4,
    parameter int LAT_DIVS = 7,
    parameter int LAT_DIVD = 17,
    localparam int RW      = $clog2(NREG),
    localparam int LAT_MAX = max_of6(LAT_ALU, LAT_SHF, LAT_LD, LAT_MAC, LAT_DIVS, LAT_DIVD),
    localparam int CNT_W   = $clog2(LAT_MAX + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush_i,
    input  logic [ISSUE_W-1:0]          iss_vld_i,
    input  logic [ISSUE_W*RW-1:0]       iss_dst_i,
    input  logic [ISSUE_W*CLS_W-1:0]    iss_cls_i,
    input  logic [NCAND*NSRC-1:0]       src_vld_i,
    input  logic [NCAND*NSRC*RW-1:0]    src_reg_i,
    input  logic [NCAND*NSRC*STG_W-1:0] src_stg_i,
    output logic [NCAND-1:0]            cand_ready_o,
    output logic [NCAND-1:0]            cand_stall_o
);

    logic [CNT_W-1:0]      slot_lat [ISSUE_W];
    logic [NREG-1:0]       wr_en;
    logic [CNT_W-1:0]      wr_lat   [NREG];
    logic [CNT_W-1:0]      cnt_arr  [NREG];
    logic [NREG*CNT_W-1:0] cnt_flat;

    for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
        sbi_lat_decode #(
            .CNT_W(CNT_W), .LAT_ALU(LAT_ALU), .LAT_SHF(LAT_SHF), .LAT_LD(LAT_LD),
            .LAT_MAC(LAT_MAC), .LAT_DIVS(LAT_DIVS), .LAT_DIVD(LAT_DIVD)
        ) u_dec (
            .cls_i(iss_cls_i[s*CLS_W +: CLS_W]),
            .lat_o(slot_lat[s])
        );
    end

    // Per-register write select; later slots override earlier ones.
    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            wr_en[r]  = 1'b0;
            wr_lat[r] = '0;
            for (int s = 0; s < ISSUE_W; s++) begin
                if (iss_vld_i[s] && iss_dst_i[s*RW +: RW] == RW'(r)) begin
                    wr_en[r]  = 1'b1;
                    wr_lat[r] = slot_lat[s];
                end
            end
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        sbi_reg_counter #(.CNT_W(CNT_W), .LAT_MAX(LAT_MAX)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush_i (flush_i),
            .wr_en_i (wr_en[r]),
            .wr_lat_i(wr_lat[r]),
            .cnt_o   (cnt_arr[r])
        );
        assign cnt_flat[r*CNT_W +: CNT_W] = cnt_arr[r];
    end

    for (genvar c = 0; c < NCAND; c++) begin : g_cand
        sbi_src_check #(.NREG(NREG), .NSRC(NSRC), .CNT_W(CNT_W)) u_chk (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_flat_i(cnt_flat),
            .vld_i     (src_vld_i[c*NSRC +: NSRC]),
            .reg_i     (src_reg_i[c*NSRC*RW +: NSRC*RW]),
            .stg_i     (src_stg_i[c*NSRC*STG_W +: NSRC*STG_W]),
            .ready_o   (cand_ready_o[c])
        );
    end

    assign cand_stall_o = ~cand_ready_o;

    AST_FLUSH_ALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (&cand_ready_o)); // R9

    if (ISSUE_W >= 2) begin : g_pair_chk
        logic [RW-1:0] young_dst;
        logic [RW-1:0] elder_dst;
        assign young_dst = iss_dst_i[(ISSUE_W-1)*RW +: RW];
        assign elder_dst = iss_dst_i[(ISSUE_W-2)*RW +: RW];

        AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush_i && iss_vld_i[ISSUE_W-1] && iss_vld_i[ISSUE_W-2] && young_dst == elder_dst)
            |=> (cnt_arr[$past(young_dst)] == $past(slot_lat[ISSUE_W-1]))); // R5
    end

endmodule

// File: tb/sbi_interlock_tb.sv
// Bench: behavioural per-register countdown model compared every cycle.
module sbi_interlock_tb_top;

    localparam int NREG = 16;
    localparam int IW   = 2;
    localparam int NC   = 2;
    localparam int NS   = 2;
    localparam int RW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic [IW-1:0]      iss_vld = '0;
    logic [IW*RW-1:0]   iss_dst = '0;
    logic [IW*3-1:0]    iss_cls = '0;
    logic [NC*NS-1:0]   src_vld = '0;
    logic [NC*NS*RW-1:0] src_reg = '0;
    logic [NC*NS*2-1:0] src_stg = '0;
    logic [NC-1:0]      ready;
    logic [NC-1:0]      stall;

    int mcnt [NREG];
    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    sbi_interlock dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .iss_vld_i(iss_vld), .iss_dst_i(iss_dst), .iss_cls_i(iss_cls),
        .src_vld_i(src_vld), .src_reg_i(src_reg), .src_stg_i(src_stg),
        .cand_ready_o(ready), .cand_stall_o(stall)
    );

    // Latencies per class code, from R2.
    function automatic int lat_of(input int cls);
        case (cls)
            0: return 3;
            1, 2, 3: return 4;
            4: return 7;
            5: return 17;
            default: return 0;
        endcase
    endfunction

    // Advance per read-stage code, from R6.
    function automatic int adv_of(input int stg);
        return (stg == 3) ? 0 : stg;
    endfunction

    task automatic compare();
        for (int c = 0; c < NC; c++) begin
            bit exp_rdy = 1'b1;
            for (int s = 0; s < NS; s++) begin
                int k = c*NS + s;
                if (src_vld[k] && mcnt[src_reg[k*RW +: RW]] > adv_of(src_stg[k*2 +: 2]))
                    exp_rdy = 1'b0;
            end
            checks++;
            if (ready[c] !== exp_rdy || stall[c] !== !exp_rdy) begin
                errors++;
                $display("FAIL %s cand%0d ready/stall actual=%b/%b expected=%b/%b t=%0t",
                         cur_req, c, ready[c], stall[c], exp_rdy, !exp_rdy, $time);
            end
        end
    endtask

    task automatic model_update();
        if (!rst_n || flush) begin
            for (int r = 0; r < NREG; r++) mcnt[r] = 0;
        end else begin
            for (int r = 0; r < NREG; r++) if (mcnt[r] > 0) mcnt[r]--;
            for (int s = 0; s < IW; s++)
                if (iss_vld[s]) mcnt[iss_dst[s*RW +: RW]] = lat_of(iss_cls[s*3 +: 3]);
        end
    endtask

    // Inputs are set at the falling edge; check, then take the rising edge.
    task automatic step();
        #2;
        if (rst_n) compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle_iss();
        iss_vld = '0;
        flush = 1'b0;
    endtask

    task automatic set_iss(input int s, input int dst, input int cls);
        iss_vld[s] = 1'b1;
        iss_dst[s*RW +: RW] = RW'(dst);
        iss_cls[s*3 +: 3] = 3'(cls);
    endtask

    task automatic set_src(input int c, input int s, input bit v, input int r, input int stg);
        int k = c*NS + s;
        src_vld[k] = v;
        src_reg[k*RW +: RW] = RW'(r);
        src_stg[k*2 +: 2] = 2'(stg);
    endtask

    task automatic probe_all_stages(input int r);
        set_src(0, 0, 1, r, 0);
        set_src(0, 1, 1, r, 1);
        set_src(1, 0, 1, r, 2);
        set_src(1, 1, 1, r, 3);
    endtask

    task automatic watch(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            idle_iss();
        end
    endtask

    initial begin
        for (int r = 0; r < NREG; r++) mcnt[r] = 0;
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;

        // R1: every register ready straight after reset.
        cur_req = "R1";
        for (int r = 0; r < NREG; r++) begin
            probe_all_stages(r);
            step();
        end

        // R2, R3: each class on register 5, watched from every stage.
        cur_req = "R2";
        for (int cls = 0; cls < 8; cls++) begin
            probe_all_stages(5);
            set_iss(0, 5, cls);
            step();
            idle_iss();
            cur_req = "R3";
            watch(20);
            cur_req = "R2";
        end

        // R6: stage codes 1 and 3 on a long countdown.
        cur_req = "R6";
        set_src(0, 0, 1, 7, 1); set_src(0, 1, 0, 0, 0);
        set_src(1, 0, 1, 7, 3); set_src(1, 1, 0, 0, 0);
        set_iss(1, 7, 5);
        step(); idle_iss();
        watch(19);

        // R4: shorten then lengthen a running countdown.
        cur_req = "R4";
        probe_all_stages(2);
        set_iss(0, 2, 5); step(); idle_iss();
        watch(3);
        set_iss(0, 2, 0); step(); idle_iss();
        watch(1);
        set_iss(1, 2, 4); step(); idle_iss();
        watch(2);
        set_iss(0, 2, 5); step(); idle_iss();
        watch(18);

        // R5: two slots on one register, both orders.
        cur_req = "R5";
        probe_all_stages(9);
        set_iss(0, 9, 0); set_iss(1, 9, 5); step(); idle_iss();
        watch(18);
        set_iss(0, 9, 5); set_iss(1, 9, 0); step(); idle_iss();
        watch(5);

        // R10: candidate reads in the same cycle as the write.
        cur_req = "R10";
        probe_all_stages(11);
        set_iss(0, 11, 4); step(); idle_iss();
        watch(2);
        set_iss(1, 11, 5); step(); idle_iss();
        watch(4);

        // R9: flush mid-countdown, and flush together with writes.
        cur_req = "R9";
        probe_all_stages(11);
        flush = 1'b1; step(); idle_iss();
        watch(2);
        set_iss(0, 4, 5); set_iss(1, 11, 5); step(); idle_iss();
        watch(3);
        flush = 1'b1; set_iss(0, 11, 5); set_iss(1, 4, 4); step(); idle_iss();
        set_src(0, 0, 1, 4, 0);
        watch(3);

        // R8: invalid sources aimed at a busy register.
        cur_req = "R8";
        set_iss(0, 6, 5); step(); idle_iss();
        for (int i = 0; i < 10; i++) begin
            for (int k = 0; k < 4; k++) set_src(k/2, k%2, 0, 6, i%4);
            step();
        end
        set_src(1, 1, 1, 6, 2);
        watch(10);

        // R7: random mix over a small register subset.
        cur_req = "R7";
        for (int i = 0; i < 4000; i++) begin
            for (int s = 0; s < IW; s++) begin
                iss_vld[s] = ($urandom_range(0, 2) == 0);
                iss_dst[s*RW +: RW] = RW'($urandom_range(0, 5));
                iss_cls[s*3 +: 3] = 3'($urandom_range(0, 7));
            end
            flush = ($urandom_range(0, 60) == 0);
            for (int k = 0; k < NC*NS; k++)
                set_src(k/NS, k%NS, ($urandom_range(0, 4) != 0),
                        $urandom_range(0, 6), $urandom_range(0, 3));
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL %s watchdog actual=running expected=finished", cur_req);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule